// File: doc/BRIEF.md
# Serial Peripheral Port with Sticky Error Flags

This block is a byte-wide SPI port that works either as the bus master, making its own bit clock, or as a slave clocked from the SCK pin. One 8-bit control register sets the enable, the idle level of the clock and a 4-bit operating mode. It also holds two status flags that stay set until they are cleared. A single data buffer sits between the CPU and a shift register. A CPU write to the buffer loads the shift register. In master mode that write also starts a transfer. When a transfer completes, the received byte goes into the buffer unless an overflow condition applies.

Bits move most significant first. The data output changes on the clock edge that leaves the idle level. The data input is sampled on the edge that returns to it. In master mode the bit clock is a fixed fraction of the system clock, or it runs at half the rate of an external timer strobe. In slave mode SCK, SDI and the active-low select are synchronised into the system clock domain before use. Software clears the flags by writing the control register with those bits at zero.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the buffer is not full, and both SCK and SDO output enables are low.
- R2: The control register bit layout is: bit 7 write-collision flag, bit 6 receive-overflow flag, bit 5 enable, bit 4 clock idle level, bits 3:0 mode. A control write stores all eight bits, so writing 0 to a flag clears it.
- R3: In master mode a buffer write starts an 8-bit transfer, shifted MSB first. When it ends, xfer_done pulses for exactly one cycle, the received byte is placed in the buffer and buf_full is set. A buffer read clears buf_full.
- R4: In master mode the full transfer takes 16 half bit periods. A half period is 2 system clocks in mode 0000, 8 in mode 0001 and 32 in mode 0010. In mode 0011 each timer strobe is one half period, so no transfer completes before the 16th strobe.
- R5: With bit 4 set, SCK sits at 1 between transfers. With bit 4 clear, SCK sits at 0.
- R6: A buffer write during an active transfer sets the write-collision flag. That write is ignored, the running transfer delivers its original byte, and the flag stays set until software clears it.
- R7: In slave mode, a byte that completes while buf_full is still set sets the overflow flag. The new byte is dropped and the buffer keeps its old contents. In master mode the overflow flag never sets.
- R8: In slave mode the port shifts a byte in from SDI on SCK edges and presents the buffer-loaded byte on SDO, one bit per clock pulse, MSB first.
- R9: In mode 0100, a high level on the select input turns SDO's enable off and drops any partial byte, so the next byte starts aligned. Mode 0101 ignores the select input.
- R10: With the enable bit at 0, both output enables stay low and a buffer write starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| buf_we | input | 1 | Data buffer write strobe |
| buf_wdata | input | 8 | Data buffer write data |
| buf_re | input | 1 | Data buffer read strobe (clears buf_full) |
| buf_rdata | output | 8 | Data buffer contents |
| buf_full | output | 1 | Buffer holds an unread received byte |
| xfer_done | output | 1 | One-cycle pulse at the end of each byte |
| tmr_strobe | input | 1 | External timer-match strobe for mode 0011 |
| sck_i | input | 1 | Serial clock input (slave modes) |
| sck_o | output | 1 | Serial clock output (master modes) |
| sck_oe | output | 1 | Serial clock output enable |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output enable |
| ss_n | input | 1 | Active-low slave select |

## Verification
The in-line assertions check several rules on every cycle. The collision flag stays set until a control write. An overflow flag can only rise after a slave-mode cycle, and the buffer is unchanged when it rises. The done pulse lasts one cycle. SCK rests at its idle level when no transfer is running. A raised select clears the bit counter, and a disabled port drops its busy state. Other behaviour can only be shown by the bench scenarios. These include the exact bit-period lengths of each clock mode, the byte values exchanged in loopback and against a bench-driven master, and the ignored colliding write leaving the original byte intact. They also include the byte realignment after a select release and the quiet pins of a disabled port.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
    localparam int DATA_W = 8;

    localparam logic [3:0] MODE_SLV_SEL   = 4'b0100;
    localparam logic [3:0] MODE_SLV_NOSEL = 4'b0101;

    typedef struct packed {
        logic       wcol;
        logic       ovf;
        logic       en;
        logic       cpol;
        logic [3:0] mode;
    } ctl_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W            = 3,
    parameter int STAGES       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= RST_VAL;
                    else        stg_q[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[i] <= RST_VAL;
                    else        stg_q[i] <= stg_q[i-1];
                end
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen #(
    parameter int HALF_FAST = 2,
    parameter int HALF_MID  = 8,
    parameter int HALF_SLOW = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    input  logic       tmr_strobe,
    output logic       tick
);
    localparam int CW = $clog2(HALF_SLOW + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;
    logic          wrap;

    always_comb begin
        case (sel)
            2'd0:    last = CW'(HALF_FAST - 1);
            2'd1:    last = CW'(HALF_MID - 1);
            default: last = CW'(HALF_SLOW - 1);
        endcase
        wrap  = (cnt_q == last);
        cnt_d = cnt_q;
        if (!run || sel == 2'd3) cnt_d = '0;
        else if (wrap)           cnt_d = '0;
        else                     cnt_d = cnt_q + 1'b1;
        tick = run && ((sel == 2'd3) ? tmr_strobe : wrap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HALF_FAST   = 2,
    parameter int HALF_MID    = 8,
    parameter int HALF_SLOW   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic [DATA_W-1:0] ctl_rdata,
    input  logic              buf_we,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_re,
    output logic [DATA_W-1:0] buf_rdata,
    output logic              buf_full,
    output logic              xfer_done,
    input  logic              tmr_strobe,
    input  logic              sck_i,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    input  logic              ss_n
);
    localparam int BCW = $clog2(DATA_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

    typedef struct packed {
        ctl_t              ctl;
        logic [DATA_W-1:0] dbuf;
        logic              full;
        logic [DATA_W-1:0] sr;
        logic              sdo;
        logic              sck;
        logic              busy;
        logic [BCW-1:0]    bitcnt;
        logic              done;
        logic              sck_prev;
    } state_t;

    state_t s_d, s_q;

    logic sck_s, sdi_s, ss_s;
    logic tick;
    logic is_master, is_slave, sel_used, active, ss_block;
    logic ev, leading, sdi_bit;
    logic [DATA_W-1:0] rx;

    spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sck_i, sdi, ss_n}),
        .q     ({sck_s, sdi_s, ss_s})
    );

    spi_rate_gen #(.HALF_FAST(HALF_FAST), .HALF_MID(HALF_MID), .HALF_SLOW(HALF_SLOW)) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (active && is_master && s_q.busy),
        .sel        (s_q.ctl.mode[1:0]),
        .tmr_strobe (tmr_strobe),
        .tick       (tick)
    );

    always_comb begin
        is_master = (s_q.ctl.mode[3:2] == 2'b00);
        is_slave  = (s_q.ctl.mode == MODE_SLV_SEL) || (s_q.ctl.mode == MODE_SLV_NOSEL);
        sel_used  = (s_q.ctl.mode == MODE_SLV_SEL);
        active    = s_q.ctl.en && (is_master || is_slave);
        ss_block  = active && sel_used && ss_s;
        sdi_bit   = is_master ? sdi : sdi_s;
        ev        = active && ((is_master && s_q.busy && tick) ||
                               (is_slave && !ss_block && (sck_s != s_q.sck_prev)));
        leading   = is_master ? (s_q.sck == s_q.ctl.cpol) : (s_q.sck_prev == s_q.ctl.cpol);
        rx        = {s_q.sr[DATA_W-2:0], sdi_bit};

        s_d          = s_q;
        s_d.done     = 1'b0;
        s_d.sck_prev = sck_s;

        if (ctl_we) s_d.ctl = ctl_t'(ctl_wdata);
        if (buf_re) s_d.full = 1'b0;

        if (!active || ss_block) begin
            s_d.busy   = 1'b0;
            s_d.bitcnt = '0;
        end else if (ev) begin
            if (is_master) s_d.sck = ~s_q.sck;
            if (leading) begin
                s_d.sdo  = s_q.sr[DATA_W-1];
                s_d.busy = 1'b1;
            end else begin
                s_d.sr     = rx;
                s_d.bitcnt = s_q.bitcnt + 1'b1;
                if (s_q.bitcnt == LAST_BIT) begin
                    s_d.busy   = 1'b0;
                    s_d.bitcnt = '0;
                    s_d.done   = 1'b1;
                    if (is_slave && s_q.full) begin
                        s_d.ctl.ovf = 1'b1;
                    end else begin
                        s_d.dbuf = rx;
                        s_d.full = 1'b1;
                    end
                end
            end
        end

        if (buf_we) begin
            if (active && s_q.busy) begin
                s_d.ctl.wcol = 1'b1;
            end else begin
                s_d.dbuf = buf_wdata;
                s_d.sr   = buf_wdata;
                if (active && is_master) s_d.busy = 1'b1;
            end
        end

        if (!s_d.busy) s_d.sck = s_d.ctl.cpol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.sck_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctl_rdata = s_q.ctl;
    assign buf_rdata = s_q.dbuf;
    assign buf_full  = s_q.full;
    assign xfer_done = s_q.done;
    assign sck_o     = s_q.sck;
    assign sck_oe    = active && is_master;
    assign sdo       = s_q.sdo;
    assign sdo_oe    = active && (is_master || !ss_block);

    // R6: collision flag is sticky until a control write
    assert_wcol_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[7] && !ctl_we) |=> ctl_rdata[7]);

    // R7: overflow rises only after a slave-mode cycle
    assert_no_master_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[6]) |-> ($past(ctl_rdata[3:0]) == MODE_SLV_SEL ||
                                 $past(ctl_rdata[3:0]) == MODE_SLV_NOSEL));

    // R7: the buffer keeps its old byte when overflow rises
    assert_overflow_keeps_buf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_rdata[6]) |-> $stable(buf_rdata));

    // R3: completion is a single-cycle pulse
    assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    // R5: master clock rests at the idle level between transfers
    assert_idle_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !s_q.busy) |-> (sck_o == ctl_rdata[4]));

    // R9: a raised select drops the partial byte
    assert_select_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sel_used && ss_s) |=> (s_q.bitcnt == '0));

    // R10: a disabled port does not stay busy
    assert_disabled_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rdata[5] |=> !s_q.busy);
endmodule

// File: tb/spi_port_bench.sv
module spi_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic       buf_we = 1'b0;
    logic [7:0] buf_wdata = '0;
    logic       buf_re = 1'b0;
    logic [7:0] buf_rdata;
    logic       buf_full, xfer_done;
    logic       tmr_strobe = 1'b0;
    logic       sck_drv = 1'b0;
    logic       sck_o, sck_oe;
    logic       sdi_drv = 1'b0;
    logic       loopback = 1'b0;
    logic       sdo, sdo_oe;
    logic       ss_n = 1'b1;
    logic       sdi_w;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    assign sdi_w = loopback ? sdo : sdi_drv;

    spi_port u_spi_port (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_re(buf_re),
        .buf_rdata(buf_rdata), .buf_full(buf_full), .xfer_done(xfer_done),
        .tmr_strobe(tmr_strobe),
        .sck_i(sck_drv), .sck_o(sck_o), .sck_oe(sck_oe),
        .sdi(sdi_w), .sdo(sdo), .sdo_oe(sdo_oe), .ss_n(ss_n)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (xfer_done) done_cnt <= done_cnt + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wr_buf(input logic [7:0] v);
        @(negedge clk); buf_we = 1'b1; buf_wdata = v;
        @(negedge clk); buf_we = 1'b0;
    endtask

    task automatic rd_buf(output logic [7:0] v);
        @(negedge clk); buf_re = 1'b1; v = buf_rdata;
        @(negedge clk); buf_re = 1'b0;
    endtask

    task automatic wait_done(input int max, output int n);
        n = 1;
        while (!xfer_done && n < max) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic slave_bits(input logic [7:0] mosi, input int nbits, output logic [7:0] miso);
        miso = '0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); sck_drv = 1'b1; sdi_drv = mosi[7-i];
            repeat (8) @(negedge clk);
            miso[7-i] = sdo;
            sck_drv = 1'b0;
            repeat (7) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        check(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
        check(!buf_full && !sck_oe && !sdo_oe, "R1 outputs", {buf_full, sck_oe, sdo_oe}, 0);
    endtask

    task automatic t_master_loop;
        logic [7:0] v; int n;
        loopback = 1'b1;
        wr_ctl(8'h20);
        check(ctl_rdata == 8'h20, "R2 ctl store", ctl_rdata, 8'h20);
        check(sck_oe && sdo_oe && sck_o == 1'b0, "R5 idle low", {sck_oe, sdo_oe, sck_o}, 3'b110);
        wr_buf(8'hB4);
        wait_done(200, n);
        check(n >= 32 && n <= 34, "R4 mode0 length", n, 32);
        @(negedge clk);
        check(!xfer_done, "R3 single pulse", xfer_done, 0);
        check(buf_full && buf_rdata == 8'hB4, "R3 loopback byte", buf_rdata, 8'hB4);
        rd_buf(v);
        check(!buf_full, "R3 read clears full", buf_full, 0);
    endtask

    task automatic t_rates;
        logic [7:0] v; int n;
        loopback = 1'b1;
        wr_ctl(8'h21);
        wr_buf(8'h3C);
        wait_done(1000, n);
        check(n >= 128 && n <= 130, "R4 mode1 length", n, 128);
        rd_buf(v);
        wr_ctl(8'h22);
        wr_buf(8'hE7);
        wait_done(2000, n);
        check(n >= 512 && n <= 514, "R4 mode2 length", n, 512);
        rd_buf(v);
        check(v == 8'hE7, "R4 mode2 data", v, 8'hE7);
    endtask

    task automatic t_timer;
        logic [7:0] v; int d0;
        loopback = 1'b1;
        wr_ctl(8'h23);
        wr_buf(8'h5D);
        d0 = done_cnt;
        repeat (40) @(negedge clk);
        check(done_cnt == d0, "R4 no strobe no progress", done_cnt - d0, 0);
        for (int k = 0; k < 15; k++) begin
            @(negedge clk); tmr_strobe = 1'b1;
            @(negedge clk); tmr_strobe = 1'b0;
            repeat (2) @(negedge clk);
        end
        check(done_cnt == d0 && !buf_full, "R4 15 strobes", done_cnt - d0, 0);
        @(negedge clk); tmr_strobe = 1'b1;
        @(negedge clk); tmr_strobe = 1'b0;
        repeat (2) @(negedge clk);
        check(done_cnt == d0 + 1, "R4 16th strobe", done_cnt - d0, 1);
        rd_buf(v);
        check(v == 8'h5D, "R4 timer data", v, 8'h5D);
    endtask

    task automatic t_cpol;
        logic [7:0] v; int n;
        loopback = 1'b1;
        wr_ctl(8'h30);
        check(sck_o == 1'b1, "R5 idle high", sck_o, 1);
        wr_buf(8'h81);
        repeat (3) @(negedge clk);
        check(sck_o == 1'b0, "R5 leading edge leaves idle", sck_o, 0);
        wait_done(200, n);
        @(negedge clk);
        check(sck_o == 1'b1, "R5 back to idle high", sck_o, 1);
        rd_buf(v);
        check(v == 8'h81, "R5 cpol1 data", v, 8'h81);
    endtask

    task automatic t_collision;
        logic [7:0] v; int n;
        loopback = 1'b1;
        wr_ctl(8'h20);
        wr_buf(8'hA5);
        repeat (5) @(negedge clk);
        wr_buf(8'h3C);
        check(ctl_rdata[7] == 1'b1, "R6 wcol set", ctl_rdata[7], 1);
        wait_done(200, n);
        @(negedge clk);
        rd_buf(v);
        check(v == 8'hA5, "R6 colliding write ignored", v, 8'hA5);
        check(ctl_rdata[7] == 1'b1, "R6 wcol sticky", ctl_rdata[7], 1);
        wr_ctl(8'h20);
        check(ctl_rdata == 8'h20, "R2 flag cleared by write", ctl_rdata, 8'h20);
    endtask

    task automatic t_master_no_ovf;
        int n;
        loopback = 1'b1;
        wr_ctl(8'h20);
        wr_buf(8'h11);
        wait_done(200, n);
        repeat (2) @(negedge clk);
        wr_buf(8'h22);
        wait_done(200, n);
        repeat (2) @(negedge clk);
        check(ctl_rdata[6] == 1'b0, "R7 master never overflows", ctl_rdata[6], 0);
        check(buf_rdata == 8'h22, "R7 master buffer updated", buf_rdata, 8'h22);
    endtask

    task automatic t_slave;
        logic [7:0] miso, v;
        loopback = 1'b0;
        ss_n = 1'b0;
        sck_drv = 1'b0;
        wr_ctl(8'h24);
        rd_buf(v);
        repeat (4) @(negedge clk);
        check(!sck_oe && sdo_oe, "R8 slave pin enables", {sck_oe, sdo_oe}, 2'b01);
        wr_buf(8'hC3);
        slave_bits(8'h96, 8, miso);
        check(miso == 8'hC3, "R8 slave sdo byte", miso, 8'hC3);
        check(buf_full && buf_rdata == 8'h96, "R8 slave rx byte", buf_rdata, 8'h96);
        slave_bits(8'h11, 8, miso);
        check(ctl_rdata[6] == 1'b1, "R7 overflow set", ctl_rdata[6], 1);
        check(buf_rdata == 8'h96, "R7 old byte kept", buf_rdata, 8'h96);
        rd_buf(v);
        wr_ctl(8'h24);
        check(ctl_rdata[6] == 1'b0, "R7 overflow cleared", ctl_rdata[6], 0);
    endtask

    task automatic t_select;
        logic [7:0] miso, v;
        loopback = 1'b0;
        ss_n = 1'b0;
        wr_ctl(8'h24);
        slave_bits(8'hFF, 3, miso);
        @(negedge clk); ss_n = 1'b1;
        repeat (6) @(negedge clk);
        check(sdo_oe == 1'b0, "R9 select high disables sdo", sdo_oe, 0);
        ss_n = 1'b0;
        repeat (6) @(negedge clk);
        slave_bits(8'h5A, 8, miso);
        rd_buf(v);
        check(v == 8'h5A, "R9 realigned byte", v, 8'h5A);
        ss_n = 1'b1;
        wr_ctl(8'h25);
        repeat (6) @(negedge clk);
        check(sdo_oe == 1'b1, "R9 select ignored in 0101", sdo_oe, 1);
        slave_bits(8'h3E, 8, miso);
        rd_buf(v);
        check(v == 8'h3E, "R9 rx with select high in 0101", v, 8'h3E);
    endtask

    task automatic t_disabled;
        int d0;
        loopback = 1'b1;
        wr_ctl(8'h00);
        d0 = done_cnt;
        wr_buf(8'h77);
        repeat (100) @(negedge clk);
        check(done_cnt == d0, "R10 no transfer when disabled", done_cnt - d0, 0);
        check(!sck_oe && !sdo_oe, "R10 pins released", {sck_oe, sdo_oe}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_master_loop();
        t_rates();
        t_timer();
        t_cpol();
        t_collision();
        t_master_no_ovf();
        t_slave();
        t_select();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule